// File: doc/BRIEF.md
# Peripheral Interrupt Register Block

This block collects eight raw interrupt inputs from one peripheral and turns them into a single interrupt request. It first brings each input into the local clock domain. Each line is then set up for one of two detection kinds:

- **Edge:** rising, falling, both or neither.
- **Level:** active-high or active-low.

An event that qualifies on an enabled line sets a sticky latched bit for that line. The request output is high whenever any latched bit is set on a line that is still enabled.

Software reaches the block through a byte-wide register port. Reads return data one clock after the read strobe. A write either names its own address or, when `acc_first` is low, goes to the address after the previous write. This lets a burst program the three trigger bitmaps with back-to-back bytes. Enables are changed through separate set and clear addresses. Latched bits are cleared by writing ones to a clear address, so an acknowledge sequence is a disable followed by a clear.

Top module: `periph_irq_block`

## Requirements
- R1: After reset, trigger type, high polarity, low polarity, enable and latched status read 0, and `irq_out` is 0.
- R2: Reading offset 0x10 returns, for each line, the input after the synchronizer when its high-polarity bit is 1, and the inverted input when that bit is 0.
- R3: A line whose type bit (offset 0x11) is 1 detects edges. Its high-polarity bit (0x12) enables rising edges and its low-polarity bit (0x13) enables falling edges; both set means both edges, neither set means no events.
- R4: A line whose type bit is 0 detects levels, active-high when its high-polarity bit is 1 and active-low when it is 0. While the level stays active on an enabled line, the latched bit sets again one cycle after it is cleared.
- R5: Writing ones to offset 0x15 enables those lines and writing ones to 0x16 disables them; zero bits leave the enables unchanged. Reading either offset returns the enable bitmap.
- R6: Writing ones to offset 0x14 clears those latched bits. A clear beats a new event arriving in the same cycle.
- R7: A latched bit only sets on an enabled line. `irq_out` is the OR over lines of latched AND enable.
- R8: A write with `acc_first`=1 uses `reg_addr`. A write with `acc_first`=0 uses the previous write's address plus one, so three bytes at 0x11 set type, high polarity and low polarity in that order.
- R9: Offset 0x18 reads the latched bitmap, and 0x11 to 0x13 read back the trigger bitmaps. Offset 0x14 and every unmapped offset read 0.
- R10: Writes to 0x10, 0x18 and unmapped offsets change no state.
- R11: `reg_rdata` is loaded on a clock edge where `reg_rd` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 8 | Raw interrupt inputs, one per line |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| acc_first | input | 1 | 1: write uses reg_addr; 0: previous write address plus one |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench goes through every per-line combination of type and the two polarity bits, both as uniform settings and as a mixed setting with all eight combinations across the eight lines. It steps the inputs through patterns that rise and fall on different subsets of lines.

- A swapped polarity or edge sense would latch the wrong lines.
- A latch that ignores the enable would raise `irq_out` from a disabled line.
- A level line that does not re-latch after a clear, or an edge line that re-latches, shows up in the status read taken after each clear.
- Burst address stepping, the zero-bit behaviour of the enable set and clear writes, and writes to read-only or unmapped offsets are each checked by reading the state back. A broken address pointer or a write decode that is too loose would leave different values behind.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int LINES = 8;
  localparam logic [7:0] OFS_RT    = 8'h10;
  localparam logic [7:0] OFS_TYPE  = 8'h11;
  localparam logic [7:0] OFS_POLHI = 8'h12;
  localparam logic [7:0] OFS_POLLO = 8'h13;
  localparam logic [7:0] OFS_LCLR  = 8'h14;
  localparam logic [7:0] OFS_ENSET = 8'h15;
  localparam logic [7:0] OFS_ENCLR = 8'h16;
  localparam logic [7:0] OFS_GAP   = 8'h17;
  localparam logic [7:0] OFS_LSTS  = 8'h18;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign chain_d[s] = d_i;
    end else begin : g_tail
      assign chain_d[s] = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_d[s];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pirq_detect.sv
module pirq_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] rt_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] evt;

  for (genvar i = 0; i < W; i++) begin : g_line
    logic rise, fall, lvl;
    assign rise   = sync_i[i] & ~prev_q[i];
    assign fall   = ~sync_i[i] & prev_q[i];
    assign lvl    = ~(sync_i[i] ^ hi_i[i]);
    assign rt_o[i] = lvl;
    assign evt[i] = edge_i[i] ? ((hi_i[i] & rise) | (lo_i[i] & fall)) : lvl;
  end

  always_comb begin
    lat_d = (lat_q | (evt & en_i)) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= sync_i;
      lat_q  <= lat_d;
    end
  end

  assign lat_o = lat_q;

  // R6
  lat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((lat_q & $past(clr_i)) == '0));

  // R7
  lat_enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & ~$past(lat_q) & ~$past(en_i)) == '0));
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  input  logic          reg_wr,
  input  logic          acc_first,
  input  logic          reg_rd,
  input  logic [W-1:0]  rt_i,
  input  logic [W-1:0]  lat_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  type_o,
  output logic [W-1:0]  hi_o,
  output logic [W-1:0]  lo_o,
  output logic [W-1:0]  en_o,
  output logic [W-1:0]  clr_o
);
  logic [AW-1:0] ptr_q, ptr_d, wr_addr;
  logic [W-1:0]  type_q, type_d, hi_q, hi_d, lo_q, lo_d, en_q, en_d;
  logic [W-1:0]  rdata_q, rd_sel;

  assign wr_addr = acc_first ? reg_addr : AW'(ptr_q + 1'b1);

  always_comb begin
    ptr_d  = ptr_q;
    type_d = type_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    en_d   = en_q;
    clr_o  = '0;
    if (reg_wr) begin
      ptr_d = wr_addr;
      if (wr_addr == AW'(OFS_TYPE))  type_d = reg_wdata;
      if (wr_addr == AW'(OFS_POLHI)) hi_d   = reg_wdata;
      if (wr_addr == AW'(OFS_POLLO)) lo_d   = reg_wdata;
      if (wr_addr == AW'(OFS_ENSET)) en_d   = en_q | reg_wdata;
      if (wr_addr == AW'(OFS_ENCLR)) en_d   = en_q & ~reg_wdata;
      if (wr_addr == AW'(OFS_LCLR))  clr_o  = reg_wdata;
    end
  end

  always_comb begin
    rd_sel = '0;
    if (reg_addr == AW'(OFS_RT))    rd_sel = rt_i;
    if (reg_addr == AW'(OFS_TYPE))  rd_sel = type_q;
    if (reg_addr == AW'(OFS_POLHI)) rd_sel = hi_q;
    if (reg_addr == AW'(OFS_POLLO)) rd_sel = lo_q;
    if (reg_addr == AW'(OFS_ENSET)) rd_sel = en_q;
    if (reg_addr == AW'(OFS_ENCLR)) rd_sel = en_q;
    if (reg_addr == AW'(OFS_LSTS))  rd_sel = lat_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      type_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      type_q <= type_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      en_q   <= en_d;
      if (reg_rd) rdata_q <= rd_sel;
    end
  end

  assign rdata_o = rdata_q;
  assign type_o  = type_q;
  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
  assign en_o    = en_q;

  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wr_addr == AW'(OFS_ENSET)) |=> ((en_q & $past(reg_wdata)) == $past(reg_wdata)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(rdata_o));

  // R9
  gap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == AW'(OFS_GAP)) |=> (rdata_o == '0));
endmodule

// File: rtl/periph_irq_block.sv
module periph_irq_block
  import pirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_raw,
  input  logic [AW-1:0]    reg_addr,
  input  logic [LINES-1:0] reg_wdata,
  input  logic             reg_wr,
  input  logic             acc_first,
  input  logic             reg_rd,
  output logic [LINES-1:0] reg_rdata,
  output logic             irq_out
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [LINES-1:0] sync_v, type_v, hi_v, lo_v, en_v, clr_v, lat_v, rt_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pirq_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(irq_raw), .q_o(sync_v)
  );

  pirq_detect #(.W(LINES)) u_detect (
    .clk(clk), .rst_n(rst_int_n), .sync_i(sync_v), .edge_i(type_v),
    .hi_i(hi_v), .lo_i(lo_v), .en_i(en_v), .clr_i(clr_v),
    .lat_o(lat_v), .rt_o(rt_v)
  );

  pirq_regs #(.W(LINES), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .acc_first(acc_first), .reg_rd(reg_rd),
    .rt_i(rt_v), .lat_i(lat_v), .rdata_o(reg_rdata),
    .type_o(type_v), .hi_o(hi_v), .lo_o(lo_v), .en_o(en_v), .clr_o(clr_v)
  );

  assign irq_out = |(lat_v & en_v);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq_out) |-> (|lat_v));
endmodule

// File: tb/tb_periph_irq_block.sv
module tb_periph_irq_block;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_raw, reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, acc_first, reg_rd, irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m_tp, m_hi, m_lo, m_en, m_lat;

  periph_irq_block dut (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .acc_first(acc_first),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] act(input logic [7:0] r);
    return (m_hi & r) | (~m_hi & ~r);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_level();
    m_lat |= ~m_tp & act(irq_raw) & m_en;
  endtask

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h11: m_tp = d;
      8'h12: m_hi = d;
      8'h13: m_lo = d;
      8'h14: m_lat &= ~d;
      8'h15: m_en |= d;
      8'h16: m_en &= ~d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; acc_first = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    idle(2);
    model_wr(a, d);
    settle_level();
  endtask

  task automatic burst3(input logic [7:0] a, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2);
    @(negedge clk);
    reg_addr = a; reg_wdata = d0; reg_wr = 1'b1; acc_first = 1'b1;
    @(negedge clk);
    reg_addr = 8'h00; reg_wdata = d1; acc_first = 1'b0;
    @(negedge clk);
    reg_wdata = d2;
    @(negedge clk);
    reg_wr = 1'b0; acc_first = 1'b1;
    idle(2);
    model_wr(a, d0); model_wr(a + 8'd1, d1); model_wr(a + 8'd2, d2);
    settle_level();
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic drive_raw(input logic [7:0] nv);
    logic [7:0] ov, ev;
    ov = irq_raw;
    @(negedge clk);
    irq_raw = nv;
    idle(4);
    ev = m_tp & ((m_hi & nv & ~ov) | (m_lo & ~nv & ov));
    m_lat |= ev & m_en;
    settle_level();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=00 exp=01");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pats [8];
    pats = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'hA5, 8'h5A, 8'h3C, 8'h00};
    rst_n = 1'b0; irq_raw = 8'h00; reg_addr = 8'h00; reg_wdata = 8'h00;
    reg_wr = 1'b0; acc_first = 1'b1; reg_rd = 1'b0;
    m_tp = 0; m_hi = 0; m_lo = 0; m_en = 0; m_lat = 0;
    idle(3);
    rst_n = 1'b1;
    idle(6);

    // R1 reset state
    chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
    rd(8'h11, v); chk("R1 type", v, 8'h00);
    rd(8'h12, v); chk("R1 polhi", v, 8'h00);
    rd(8'h13, v); chk("R1 pollo", v, 8'h00);
    rd(8'h15, v); chk("R1 enable", v, 8'h00);
    rd(8'h18, v); chk("R1 latched", v, 8'h00);
    // R2 active-low default: raw 0 reads as active
    rd(8'h10, v); chk("R2 rt reset", v, 8'hFF);

    // R9 unmapped and clear offsets read zero
    rd(8'h00, v); chk("R9 unmapped 00", v, 8'h00);
    rd(8'h17, v); chk("R9 unmapped 17", v, 8'h00);
    rd(8'h19, v); chk("R9 unmapped 19", v, 8'h00);
    rd(8'hFF, v); chk("R9 unmapped FF", v, 8'h00);
    rd(8'h14, v); chk("R9 clear reads 0", v, 8'h00);

    // R11 rdata holds without read strobe
    rd(8'h10, v);
    @(negedge clk); reg_addr = 8'h00; idle(2);
    chk("R11 hold", reg_rdata, 8'hFF);

    // R8 burst programming, enables off
    burst3(8'h11, 8'h96, 8'h3C, 8'hE1);
    rd(8'h11, v); chk("R8 burst type", v, 8'h96);
    rd(8'h12, v); chk("R8 burst polhi", v, 8'h3C);
    rd(8'h13, v); chk("R8 burst pollo", v, 8'hE1);

    // R10 writes to read-only / unmapped offsets ignored
    wr(8'h18, 8'hFF); wr(8'h10, 8'h00); wr(8'h17, 8'h55); wr(8'h40, 8'h77);
    rd(8'h18, v); chk("R10 latched", v, 8'h00);
    rd(8'h11, v); chk("R10 type", v, 8'h96);
    rd(8'h12, v); chk("R10 polhi", v, 8'h3C);
    rd(8'h13, v); chk("R10 pollo", v, 8'hE1);
    rd(8'h15, v); chk("R10 enable", v, 8'h00);

    // R5 enable set/clear with zero bits untouched
    burst3(8'h11, 8'hFF, 8'h00, 8'h00);
    wr(8'h15, 8'h0F); wr(8'h15, 8'h30);
    rd(8'h15, v); chk("R5 enset", v, 8'h3F);
    wr(8'h16, 8'h05);
    rd(8'h16, v); chk("R5 enclr", v, 8'h3A);
    wr(8'h16, 8'hFF);

    // R6 mask-with-acknowledge on an active-high level line
    burst3(8'h11, 8'h00, 8'hFF, 8'h00);
    wr(8'h14, 8'hFF);
    drive_raw(8'h01);
    wr(8'h15, 8'h01);
    chk("R4 level latched", {7'd0, irq_out}, 8'h01);
    wr(8'h16, 8'h01); wr(8'h14, 8'h01);
    rd(8'h18, v); chk("R6 ack latched", v, m_lat);
    chk("R6 ack irq", {7'd0, irq_out}, 8'h00);
    drive_raw(8'h00);

    // Sweep of trigger configurations
    for (int mode = 0; mode < 7; mode++) begin
      logic [7:0] tv, hv, lv, ev;
      string lt;
      case (mode)
        0: begin tv = 8'h00; hv = 8'hFF; lv = 8'h00; end
        1: begin tv = 8'h00; hv = 8'h00; lv = 8'h00; end
        2: begin tv = 8'hFF; hv = 8'hFF; lv = 8'h00; end
        3: begin tv = 8'hFF; hv = 8'h00; lv = 8'hFF; end
        4: begin tv = 8'hFF; hv = 8'hFF; lv = 8'hFF; end
        5: begin tv = 8'hFF; hv = 8'h00; lv = 8'h00; end
        default: begin tv = 8'hF0; hv = 8'hCC; lv = 8'hAA; end
      endcase
      ev = mode[0] ? 8'h7E : 8'hFF;
      lt = (mode < 2) ? "R4 latched" : "R3 latched";
      wr(8'h16, 8'hFF);
      burst3(8'h11, tv, hv, lv);
      wr(8'h14, 8'hFF);
      drive_raw(8'h00);
      wr(8'h15, ev);
      for (int k = 0; k < 8; k++) begin
        drive_raw(pats[k]);
        rd(8'h18, v); chk(lt, v, m_lat);
        chk("R7 irq", {7'd0, irq_out}, {7'd0, |(m_lat & m_en)});
        rd(8'h10, v); chk("R2 rt", v, act(irq_raw));
        wr(8'h14, 8'hFF);
        rd(8'h18, v); chk("R6 after clear", v, m_lat);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule